// File: doc/BRIEF.md
# Multiply-Divide Unit with Hi/Lo Result Registers

This block adds an unsigned 32-bit multiplier and divider to an integer datapath, beside the existing ALU. Both are fully parallel combinational arrays, so each operation completes in one cycle. Two strobes choose the source of the shared result output: a multiply strobe selects the product, a divide strobe selects the quotient, and with neither strobe the ALU's own result passes through unchanged.

A double-width result does not fit the result path in one piece. The low half of the product, or the quotient, drives the result output at once and is stored in the `lo` register at the clock edge that ends the operation cycle. The high half of the product, or the remainder, is parked in a staging register at that same edge. It is copied into the `hi` register at the following edge, so `hi` is updated one cycle after `lo`. Back-to-back operations therefore overlap: while one operation's high half is being committed, the next one is being staged.

Top module: `mdu_hilo`

## Requirements
- R1: While `mul_i` is high, `result_o` equals bits 31:0 of the unsigned 64-bit product `a_i * b_i`, in the same cycle.
- R2: While `div_i` is high, `mul_i` is low and `b_i` is nonzero, `result_o` equals the unsigned quotient `a_i / b_i`, in the same cycle.
- R3: At the rising edge that ends a cycle in which `mul_i` or `div_i` is high, `lo_o` takes the value shown on `result_o` during that cycle.
- R4: After a multiply cycle, bits 63:32 of the product appear on `hi_o` at the second rising edge. This is one edge later than `lo_o`.
- R5: After a divide cycle, the remainder `a_i % b_i` appears on `hi_o` at the second rising edge, with the same timing as R4.
- R6: In a cycle with both strobes low, `result_o` equals `alu_res_i` and `lo_o` holds. `hi_o` changes only to commit a value staged by an operation in the previous cycle.
- R7: A divide with `b_i` equal to zero gives an all-ones quotient (0xFFFFFFFF) and a remainder equal to `a_i`. No other indication is raised.
- R8: If both strobes are high in one cycle, the multiply is performed and the divide is ignored, on `result_o`, `lo_o` and `hi_o` alike.
- R9: While `rst_ni` is low, `hi_o`, `lo_o` and the staging register are cleared to zero. After reset, `hi_o` stays zero until an operation commits into it.
- R10: In consecutive operation cycles, `hi_o` receives each operation's high half or remainder in issue order, each one cycle after the matching `lo_o` update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mul_i | input | 1 | Multiply strobe; selects the product |
| div_i | input | 1 | Divide strobe; selects the quotient |
| a_i | input | 32 | Multiplicand or dividend, unsigned |
| b_i | input | 32 | Multiplier or divisor, unsigned |
| alu_res_i | input | 32 | Result of the existing ALU, passed through when no strobe is high |
| result_o | output | 32 | Selected result: product low half, quotient or ALU result |
| hi_o | output | 32 | Hi register: product high half or remainder |
| lo_o | output | 32 | Lo register: product low half or quotient |

## Verification
The bench drives the extremes of the datapath. One case is the all-ones square, whose high half is 0xFFFFFFFE; a dropped carry in the partial-product chain would corrupt it. Other cases are a dividend smaller than the divisor and a zero divisor. A divider that special-cases zero incorrectly, or that drops the last restoring step, would return a wrong remainder here rather than the dividend. Back-to-back mixed operations with idle gaps show whether `hi` is updated one cycle late, as required. A design that writes `hi` in the operation cycle would show each value an edge early. A design without a staging register would lose the earlier value of a pair. The bench also asserts both strobes together, to confirm that the divide cannot win the result mux or reach `hi`.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    SEL_ALU = 2'd0,
    SEL_MUL = 2'd1,
    SEL_DIV = 2'd2
  } res_sel_e;

  // multiply wins when both strobes are set
  function automatic res_sel_e decode_sel(input logic mul, input logic div);
    if (mul)      return SEL_MUL;
    else if (div) return SEL_DIV;
    else          return SEL_ALU;
  endfunction

endpackage

// File: rtl/mdu_mul_array.sv
module mdu_mul_array #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);

  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] acc [W+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] pp;
    assign pp         = b_i[i] ? ({{W{1'b0}}, a_i} << i) : '0;
    assign acc[i+1]   = acc[i] + pp;
  end

  assign prod_o = acc[W];

endmodule

// File: rtl/mdu_div_array.sv
module mdu_div_array #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);

  // restoring array; a zero divisor falls out as q = all ones, r = a
  logic [W-1:0] rem [W+1];
  logic [W:0]   dvs;

  assign dvs    = {1'b0, b_i};
  assign rem[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_stage
    logic [W:0] trial;
    logic [W:0] diff;
    logic       ge;
    assign trial      = {rem[k], a_i[W-1-k]};
    assign diff       = trial - dvs;
    assign ge         = (trial >= dvs);
    assign rem[k+1]   = ge ? diff[W-1:0] : trial[W-1:0];
    assign quot_o[W-1-k] = ge;
  end

  assign rem_o = rem[W];

endmodule

// File: rtl/mdu_hilo_regs.sv
module mdu_hilo_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         op_vld_i,
  input  logic [W-1:0] lo_d_i,
  input  logic [W-1:0] hi_d_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  logic [W-1:0] stage_q;
  logic         pend_q;
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      pend_q  <= 1'b0;
      lo_q    <= '0;
    end else begin
      pend_q <= op_vld_i;
      if (op_vld_i) begin
        stage_q <= hi_d_i;
        lo_q    <= lo_d_i;
      end
    end
  end

  // hi commits one edge after staging
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_q <= '0;
    else if (pend_q) hi_q <= stage_q;
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mul_i,
  input  logic         div_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] alu_res_i,
  output logic [W-1:0] result_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] prod;
  logic [W-1:0]  quot;
  logic [W-1:0]  rem;
  res_sel_e      sel;
  logic [W-1:0]  hi_d;
  logic          op_vld;

  mdu_mul_array #(.W(W)) i_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  mdu_div_array #(.W(W)) i_div (
    .a_i    (a_i),
    .b_i    (b_i),
    .quot_o (quot),
    .rem_o  (rem)
  );

  assign sel    = decode_sel(mul_i, div_i);
  assign op_vld = (sel != SEL_ALU);

  always_comb begin
    unique case (sel)
      SEL_MUL: begin result_o = prod[W-1:0]; hi_d = prod[PW-1:W]; end
      SEL_DIV: begin result_o = quot;        hi_d = rem;          end
      default: begin result_o = alu_res_i;   hi_d = '0;           end
    endcase
  end

  mdu_hilo_regs #(.W(W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_vld_i (op_vld),
    .lo_d_i   (result_o),
    .hi_d_i   (hi_d),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
  );

endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mul_i,
  input logic         div_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] alu_res_i,
  input logic [W-1:0] result_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);

  logic [2*W-1:0] ref_prod;
  logic           dv;
  logic           dz;

  assign ref_prod = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign dv       = div_i && !mul_i && (b_i != '0);
  assign dz       = div_i && !mul_i && (b_i == '0);

  assert_mul_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_i |-> result_o == ref_prod[W-1:0]);

  assert_div_quot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv |-> result_o == a_i / b_i);

  assert_lo_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_i || div_i) |=> lo_o == $past(result_o));

  assert_hi_mul_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mul_i) |=> hi_o == $past(ref_prod[2*W-1:W], 2));

  assert_hi_rem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dv) |=> hi_o == $past(a_i % b_i, 2));

  assert_idle_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mul_i || div_i) |-> result_o == alu_res_i);

  assert_idle_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mul_i || div_i) |=> $stable(lo_o));

  assert_dz_quot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz |-> result_o == '1);

  assert_dz_rem_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dz) |=> hi_o == $past(a_i, 2));

endmodule

bind mdu_hilo mdu_hilo_chk #(.W(W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mul_i     (mul_i),
  .div_i     (div_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .alu_res_i (alu_res_i),
  .result_o  (result_o),
  .hi_o      (hi_o),
  .lo_o      (lo_o)
);

// File: tb/test_mdu_hilo.sv
module test_mdu_hilo;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mul_i = 1'b0;
  logic        div_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] alu_res_i = '0;
  logic [31:0] result_o;
  logic [31:0] hi_o;
  logic [31:0] lo_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int          due;
    bit          is_hi;
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_lo = '0;
  logic [31:0] m_hi_last = '0;

  always #10 clk_i = ~clk_i;

  mdu_hilo i_mdu_hilo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mul_i     (mul_i),
    .div_i     (div_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .alu_res_i (alu_res_i),
    .result_o  (result_o),
    .hi_o      (hi_o),
    .lo_o      (lo_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: compare hi/lo as they come due
  always @(negedge clk_i) begin
    cyc++;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.is_hi) check(e.req, hi_o, e.val);
      else         check(e.req, lo_o, e.val);
    end
  end

  // driver: kind 0 idle, 1 mul, 2 div, 3 both
  task automatic drive(input int kind, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] alu);
    logic [63:0] p;
    logic [31:0] res, hi, q, r;
    string       rq, hq;
    @(negedge clk_i);
    #1;
    mul_i     = (kind == 1) || (kind == 3);
    div_i     = (kind == 2) || (kind == 3);
    a_i       = a;
    b_i       = b;
    alu_res_i = alu;
    p = {32'd0, a} * {32'd0, b};
    if (b == 0) begin q = '1; r = a; end
    else        begin q = a / b; r = a % b; end
    #1;
    if (kind == 0) begin
      check("R6 idle result", result_o, alu);
      sb.push_back('{cyc + 1, 1'b0, m_lo, "R6 lo hold"});
      sb.push_back('{cyc + 2, 1'b1, m_hi_last, "R6 hi hold"});
    end else begin
      if (kind == 2) begin
        res = q; hi = r;
        rq = (b == 0) ? "R7 dz quotient" : "R2 quotient";
        hq = (b == 0) ? "R7 dz remainder" : "R5 remainder to hi";
      end else begin
        res = p[31:0]; hi = p[63:32];
        rq = (kind == 3) ? "R8 priority result" : "R1 product low";
        hq = (kind == 3) ? "R8 priority hi" : "R4 product high to hi";
      end
      check(rq, result_o, res);
      m_lo = res;
      m_hi_last = hi;
      sb.push_back('{cyc + 1, 1'b0, res, "R3 lo write"});
      sb.push_back('{cyc + 2, 1'b1, hi, hq});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset hi", hi_o, 32'd0);
    check("R9 reset lo", lo_o, 32'd0);
    @(negedge clk_i);
    #1 rst_ni = 1'b1;
    drive(0, 32'h1, 32'h2, 32'hA5A5_0001);
    drive(0, 32'h0, 32'h0, 32'h0000_1234);
    drive(1, 32'd7, 32'd6, 32'h0);
    drive(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    drive(0, 32'h0, 32'h0, 32'hDEAD_BEEF);
    drive(2, 32'd100, 32'd7, 32'h0);
    drive(2, 32'd3, 32'd10, 32'h0);
    drive(2, 32'h1234_5678, 32'd0, 32'h0);
    drive(0, 32'h0, 32'h0, 32'h0);
    drive(3, 32'h8000_0001, 32'd3, 32'h0);
    drive(0, 32'h0, 32'h0, 32'h0);
    // R10 back-to-back mixed ops
    drive(1, 32'h0001_0000, 32'h0003_0000, 32'h0);
    drive(2, 32'hFFFF_FFFF, 32'd16, 32'h0);
    drive(1, 32'hFFFF_FFFF, 32'd2, 32'h0);
    drive(2, 32'd0, 32'd0, 32'h0);
    for (int i = 0; i < 300; i++)
      drive(int'($urandom_range(0, 3)), $urandom(), ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom(),
            $urandom());
    drive(0, 32'h0, 32'h0, 32'h0);
    drive(0, 32'h0, 32'h0, 32'h0);
    repeat (3) @(negedge clk_i);
    if (sb.size() != 0) check("R10 scoreboard drained", 32'(sb.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule